// File: doc/BRIEF.md
# Expanded Memory Page Mapper

This block translates host memory accesses that land in a 64KB bus frame into physical addresses of a banked RAM array. The frame is split into four contiguous 16KB windows, picked by bus address bits [15:14]. Each window has an 8-bit page register. The host loads these registers with 8-bit I/O writes at a configurable base port. A fifth I/O register holds one extension bit per window and lifts the backing store from 2MB to 4MB.

When a window's extension bit is clear, page bit 7 acts as an unmap flag. With that bit set, no RAM device is selected and the data bus is left released, which matches the older 2MB arrangement. When the extension bit is set, page bit 7 becomes the top physical address line and selects the upper device group. Bus offset bits [13:0] pass through unchanged. Page bits [6:0] form physical bits [20:14].

Top module: `emm_page_mapper`

## Requirements
- R1: After reset, every page register and every extension bit is zero. An access to window n reaches physical page 0 in the lower group, with the select asserted.
- R2: An I/O write to base+n (n = 0..3) loads the page register of window n only. A hit then gives phys_addr[13:0] = mem_addr[13:0] and phys_addr[20:14] = page[6:0].
- R3: An I/O write to base+4 loads the extension bits from data bits [3:0], with bit n for window n. Writes to any port outside base+0..base+4 change no register.
- R4: If a window's extension bit is 0 and its page bit 7 is 1, an access to it asserts neither ram_cs, bank_upper nor data_drive.
- R5: If a window's extension bit is 0 and its page bit 7 is 0, an access asserts ram_cs, with phys_addr[21] = 0 and bank_upper = 0.
- R6: If a window's extension bit is 1, phys_addr[21] and bank_upper both equal page bit 7, and ram_cs is asserted.
- R7: The extension bit and page register used for an access are those of the window addressed by mem_addr[15:14]. The settings of other windows have no effect.
- R8: With mem_en low, or with mem_addr[19:16] different from the frame segment parameter, ram_cs and data_drive stay low.
- R9: data_drive is high only for a read (mem_rd) that asserts ram_cs. A write to a mapped window asserts ram_cs with data_drive low.
- R10: A register write takes effect at the clock edge that samples io_wr. A memory access during the write cycle is translated with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_addr | input | 10 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| mem_en | input | 1 | Global memory enable, ahead of window decode |
| mem_rd | input | 1 | Memory read in progress |
| mem_wr | input | 1 | Memory write in progress |
| mem_addr | input | 20 | Bus memory address |
| phys_addr | output | 22 | Physical RAM address; bit 21 is the extra top line |
| bank_upper | output | 1 | High selects the upper device group, low the lower |
| ram_cs | output | 1 | RAM chip-select enable |
| data_drive | output | 1 | Enable for driving read data onto the bus |

## Verification
The register file is the block's only state, and it can only be seen through translation. A page register that is corrupted or loaded for the wrong window shows up on the next memory access as a wrong phys_addr[20:14]. A lost or misplaced extension bit shows up as a flipped bank_upper, or as ram_cs wrongly asserted or dropped, when bit 7 is set. Because the memory path is combinational, any such fault appears in the same cycle as the first access that follows the faulty write. The write-cycle probe catches a mapper that forwards new data early.

// File: rtl/emm_pkg.sv
package emm_pkg;
    localparam int NUM_WIN   = 4;
    localparam int WIN_IDX_W = $clog2(NUM_WIN);
    localparam int PAGE_W    = 8;
    localparam int WIN_AW    = 14;
    localparam int BUS_AW    = 20;
    localparam int FRAME_AW  = WIN_AW + WIN_IDX_W;
    localparam int SEG_W     = BUS_AW - FRAME_AW;
    localparam int PHYS_AW   = WIN_AW + PAGE_W;
    localparam int IO_AW     = 10;
    localparam int MODE_OFF  = NUM_WIN;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic  ext_mode;
        page_t page;
    } win_cfg_t;

    typedef struct packed {
        logic              upper;
        logic [PAGE_W-2:0] frame;
        logic [WIN_AW-1:0] offset;
    } phys_addr_t;

    // A window is reachable unless it is in legacy mode with its top page bit set.
    function automatic logic win_reachable(win_cfg_t c);
        return c.ext_mode || !c.page[PAGE_W-1];
    endfunction
endpackage

// File: rtl/emm_regfile.sv
module emm_regfile
    import emm_pkg::*;
#(
    parameter logic [IO_AW-1:0] IO_BASE = 10'h260
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  io_wr,
    input  logic [IO_AW-1:0]      io_addr,
    input  logic [7:0]            io_wdata,
    output win_cfg_t [NUM_WIN-1:0] cfg
);
    logic [IO_AW-1:0]   off;
    logic               wr_hit;
    page_t              page_q [NUM_WIN];
    logic [NUM_WIN-1:0] mode_q;

    assign off    = io_addr - IO_BASE;
    assign wr_hit = io_wr && (off <= IO_AW'(MODE_OFF));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_hit && off == IO_AW'(MODE_OFF)) begin
            mode_q <= io_wdata[NUM_WIN-1:0];
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst) begin
                page_q[g] <= '0;
            end else if (wr_hit && off == IO_AW'(g)) begin
                page_q[g] <= io_wdata;
            end
        end

        assign cfg[g].ext_mode = mode_q[g];
        assign cfg[g].page     = page_q[g];

        assert_page_load_R2: assert property (@(posedge clk) disable iff (rst)
            (io_wr && io_addr == IO_BASE + IO_AW'(g)) |=> (cfg[g].page == $past(io_wdata)));

        assert_page_hold_R3: assert property (@(posedge clk) disable iff (rst)
            !(io_wr && io_addr == IO_BASE + IO_AW'(g)) |=> $stable(cfg[g].page));
    end

    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == IO_BASE + IO_AW'(MODE_OFF)) |=> $stable(mode_q));
endmodule

// File: rtl/emm_window_dec.sv
module emm_window_dec
    import emm_pkg::*;
#(
    parameter logic [SEG_W-1:0] FRAME_SEG = 4'hD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_en,
    input  logic [BUS_AW-1:0]  mem_addr,
    output logic [NUM_WIN-1:0] win_sel
);
    logic                 in_frame;
    logic [WIN_IDX_W-1:0] idx;

    assign in_frame = mem_en && (mem_addr[BUS_AW-1:FRAME_AW] == FRAME_SEG);
    assign idx      = mem_addr[FRAME_AW-1:WIN_AW];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_sel
        assign win_sel[g] = in_frame && (idx == WIN_IDX_W'(g));
    end

    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_sel));

    assert_sel_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (win_sel == '0));
endmodule

// File: rtl/emm_xlate.sv
module emm_xlate
    import emm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [NUM_WIN-1:0]     win_sel,
    input  logic [WIN_AW-1:0]      offset,
    input  logic                   mem_rd,
    output phys_addr_t             phys,
    output logic                   bank_upper,
    output logic                   ram_cs,
    output logic                   data_drive
);
    win_cfg_t act;
    logic     any_sel;

    always_comb begin
        act = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_sel[i]) act = act | cfg[i];
        end
    end

    assign any_sel      = |win_sel;
    assign phys.upper   = act.ext_mode && act.page[PAGE_W-1];
    assign phys.frame   = act.page[PAGE_W-2:0];
    assign phys.offset  = offset;
    assign ram_cs       = any_sel && win_reachable(act);
    assign bank_upper   = ram_cs && phys.upper;
    assign data_drive   = ram_cs && mem_rd;

    assert_upper_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
        bank_upper |-> (ram_cs && phys.upper));

    assert_drive_read_R9: assert property (@(posedge clk) disable iff (rst)
        data_drive |-> (mem_rd && ram_cs));

    assert_cs_needs_sel_R8: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> any_sel);
endmodule

// File: rtl/emm_page_mapper.sv
module emm_page_mapper
    import emm_pkg::*;
#(
    parameter logic [IO_AW-1:0] IO_BASE   = 10'h260,
    parameter logic [SEG_W-1:0] FRAME_SEG = 4'hD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_wr,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [7:0]         io_wdata,
    input  logic               mem_en,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic [BUS_AW-1:0]  mem_addr,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               bank_upper,
    output logic               ram_cs,
    output logic               data_drive
);
    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     win_sel;
    phys_addr_t             phys;

    emm_regfile #(.IO_BASE(IO_BASE)) u_regs (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .cfg(cfg)
    );

    emm_window_dec #(.FRAME_SEG(FRAME_SEG)) u_dec (
        .clk(clk), .rst(rst), .mem_en(mem_en), .mem_addr(mem_addr),
        .win_sel(win_sel)
    );

    emm_xlate u_xlate (
        .clk(clk), .rst(rst), .cfg(cfg), .win_sel(win_sel),
        .offset(mem_addr[WIN_AW-1:0]), .mem_rd(mem_rd), .phys(phys),
        .bank_upper(bank_upper), .ram_cs(ram_cs), .data_drive(data_drive)
    );

    assign phys_addr = phys;

    assert_no_en_no_cs_R8: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (!ram_cs && !data_drive));

    assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_rd) |-> !data_drive);

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> (phys_addr[WIN_AW-1:0] == mem_addr[WIN_AW-1:0]));
endmodule

// File: tb/emm_page_mapper_tb.sv
module emm_page_mapper_tb;
    localparam logic [9:0] BASE = 10'h260;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic [9:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        mem_en, mem_rd, mem_wr;
    logic [19:0] mem_addr;
    logic [21:0] phys_addr;
    logic        bank_upper, ram_cs, data_drive;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    emm_page_mapper u_dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .mem_en(mem_en), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .phys_addr(phys_addr),
        .bank_upper(bank_upper), .ram_cs(ram_cs), .data_drive(data_drive)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] exp_phys(logic [7:0] pg, logic md, logic [19:0] a);
        return {md & pg[7], pg[6:0], a[13:0]};
    endfunction

    task automatic io_write(logic [9:0] a, logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic access(logic en, logic rd, logic wr, logic [19:0] a);
        @(negedge clk);
        mem_en = en; mem_rd = rd; mem_wr = wr; mem_addr = a;
        #2;
    endtask

    task automatic t_reset;
        for (int w = 0; w < 4; w++) begin
            logic [19:0] a;
            a = 20'hD0000 | (20'(w) << 14) | 20'h0ABC;
            access(1, 1, 0, a);
            chk("R1 phys", 32'(phys_addr), 32'(exp_phys(8'h00, 0, a)));
            chk("R1 cs", 32'(ram_cs), 1);
            chk("R1 upper", 32'(bank_upper), 0);
        end
    endtask

    task automatic t_page;
        io_write(BASE + 10'd2, 8'h15);
        access(1, 1, 0, 20'hD8123);
        chk("R2 phys win2", 32'(phys_addr), 32'(exp_phys(8'h15, 0, 20'hD8123)));
        access(1, 1, 0, 20'hD4123);
        chk("R2 win1 untouched", 32'(phys_addr), 32'(exp_phys(8'h00, 0, 20'hD4123)));
    endtask

    task automatic t_legacy;
        io_write(BASE + 10'd1, 8'h85);
        access(1, 1, 0, 20'hD4010);
        chk("R4 cs", 32'(ram_cs), 0);
        chk("R4 drive", 32'(data_drive), 0);
        chk("R4 upper", 32'(bank_upper), 0);
        io_write(BASE + 10'd1, 8'h05);
        access(1, 1, 0, 20'hD4010);
        chk("R5 cs", 32'(ram_cs), 1);
        chk("R5 phys", 32'(phys_addr), 32'(exp_phys(8'h05, 0, 20'hD4010)));
        chk("R5 upper", 32'(bank_upper), 0);
    endtask

    task automatic t_ext;
        io_write(BASE + 10'd4, 8'h02);
        io_write(BASE + 10'd1, 8'h85);
        access(1, 1, 0, 20'hD7FFF);
        chk("R6 cs", 32'(ram_cs), 1);
        chk("R6 phys", 32'(phys_addr), 32'(exp_phys(8'h85, 1, 20'hD7FFF)));
        chk("R6 upper", 32'(bank_upper), 1);
        io_write(BASE + 10'd1, 8'h05);
        access(1, 1, 0, 20'hD4001);
        chk("R6 lower", 32'(bank_upper), 0);
        chk("R6 lower phys", 32'(phys_addr), 32'(exp_phys(8'h05, 1, 20'hD4001)));
        io_write(BASE + 10'd1, 8'h85);
        io_write(BASE + 10'd3, 8'h90);
        access(1, 1, 0, 20'hDC000);
        chk("R7 win3 legacy unmapped", 32'(ram_cs), 0);
        access(1, 1, 0, 20'hD4000);
        chk("R7 win1 ext mapped", 32'(ram_cs), 1);
        chk("R7 win1 upper", 32'(bank_upper), 1);
    endtask

    task automatic t_bad_io;
        io_write(BASE + 10'd5, 8'hFF);
        io_write(BASE - 10'd1, 8'hFF);
        io_write(BASE + 10'd7, 8'hFF);
        access(1, 1, 0, 20'hD0044);
        chk("R3 win0 unchanged", 32'(phys_addr), 32'(exp_phys(8'h00, 0, 20'hD0044)));
        access(1, 1, 0, 20'hD4044);
        chk("R3 mode unchanged", 32'(bank_upper), 1);
        access(1, 1, 0, 20'hDC044);
        chk("R3 win3 unchanged", 32'(ram_cs), 0);
    endtask

    task automatic t_gate;
        access(0, 1, 0, 20'hD0000);
        chk("R8 mem_en low cs", 32'(ram_cs), 0);
        chk("R8 mem_en low drive", 32'(data_drive), 0);
        access(1, 1, 0, 20'hC0000);
        chk("R8 outside frame", 32'(ram_cs), 0);
        access(1, 1, 0, 20'hE4000);
        chk("R8 above frame", 32'(ram_cs), 0);
    endtask

    task automatic t_write;
        access(1, 0, 1, 20'hD0100);
        chk("R9 write cs", 32'(ram_cs), 1);
        chk("R9 write drive", 32'(data_drive), 0);
        access(1, 1, 0, 20'hD0100);
        chk("R9 read drive", 32'(data_drive), 1);
    endtask

    task automatic t_timing;
        @(negedge clk);
        io_wr = 1'b1; io_addr = BASE; io_wdata = 8'h33;
        mem_en = 1'b1; mem_rd = 1'b1; mem_wr = 1'b0; mem_addr = 20'hD0200;
        #2;
        chk("R10 old value", 32'(phys_addr), 32'(exp_phys(8'h00, 0, 20'hD0200)));
        @(negedge clk);
        io_wr = 1'b0;
        #2;
        chk("R10 new value", 32'(phys_addr), 32'(exp_phys(8'h33, 0, 20'hD0200)));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
        mem_en = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0; mem_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_page();
        t_legacy();
        t_ext();
        t_bad_io();
        t_gate();
        t_write();
        t_timing();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule